// File: doc/BRIEF.md
# Programmable Baud-Rate Generator Bank

This block holds a set of independent rate dividers that all run from one shared reference clock. The reference clock is the engine clock divided by two and is made outside this block. Each divider produces a clock-enable tick, one reference-clock cycle wide, at a rate that software programs. Downstream serial channels use these ticks as their bit or sample strobes. Choosing which channel uses which tick is done elsewhere.

Each generator is set up by writing one 32-bit configuration word through a write port, with the generator picked by index. The word carries three things: a run bit, a bit that places a fixed divide-by-16 stage in front of the main divider, and a field holding the division ratio minus one. A write restarts the generator's count from the beginning. Without the prescaler, an odd ratio is not a legal setting. Writing one raises a shared error flag that stays set until reset.

Top module: `brg_bank`

## Requirements
- R1: After reset every tick output is low, the error flag is low and every generator is stopped.
- R2: Configuration word layout: bit 0 is the run bit, bit 1 selects the divide-by-16 prescaler, and bits [19:8] hold the ratio minus one (d). All other bits are ignored.
- R3: With the prescaler off and the run bit set, the ratio is N = d+1. The first tick occurs in cycle N-1, where cycle 0 is the first cycle after the write edge. Later ticks follow every N cycles.
- R4: With the prescaler on, the period is 16*N cycles. The first tick occurs in cycle 16*N-1 after the write.
- R5: For any period above one cycle, each tick is high for exactly one cycle.
- R6: A generator whose run bit is clear produces no ticks, and writing a cleared run bit silences it from cycle 0 onward.
- R7: Any write to a generator restarts its phase, so the next tick comes one full period after that write.
- R8: A write to one generator does not shift the tick schedule of any other generator.
- R9: A write to a valid generator with the prescaler off and d even (odd ratio) sets the error flag, visible from cycle 0. Legal writes leave the flag unchanged.
- R10: Once set, the error flag stays high until reset, whatever is written afterwards.
- R11: A write whose index is 16 or above changes no generator and does not touch the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (engine clock divided by two) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | 5 | Generator index for the write |
| wr_data | input | 32 | Configuration word |
| tick | output | 16 | One clock-enable tick per generator |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
The divider is run with small even ratios, with the prescaler both off and on, and with ratios of 1 and 3. Comparing first-tick and second-tick positions tells an off-by-one reload apart from a wrong prescale count. A configuration word padded with ones in the unused bits shows that those bits are really ignored. A rewrite in the middle of a period shows that the phase restarts. A second write in the middle of another generator's period shows that its schedule is untouched. Indices just beyond the valid range catch address aliasing. Odd and even ratios, each with the prescaler off and on, separate the error rule from the run state.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int BRG_WORD_W  = 32;
    localparam int BRG_DIV_W   = 12;
    localparam int BRG_DIV_LSB = 8;
    localparam int BRG_EN_BIT  = 0;
    localparam int BRG_PRE_BIT = 1;

    typedef struct packed {
        logic [BRG_DIV_W-1:0] div_m1;
        logic                 pre;
        logic                 en;
    } brg_cfg_t;

    function automatic brg_cfg_t brg_decode(input logic [BRG_WORD_W-1:0] w);
        brg_cfg_t c;
        c.en     = w[BRG_EN_BIT];
        c.pre    = w[BRG_PRE_BIT];
        c.div_m1 = w[BRG_DIV_LSB +: BRG_DIV_W];
        return c;
    endfunction

    // ratio = div_m1 + 1; odd ratio with no prescaler is illegal
    function automatic logic brg_ratio_illegal(input brg_cfg_t c);
        return !c.pre && !c.div_m1[0];
    endfunction

endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
    parameter int PRE_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    input  logic bypass,
    output logic step
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt <= PRE_TOP;
        end else if (run && !bypass) begin
            cnt <= (cnt == '0) ? PRE_TOP : cnt - 1'b1;
        end
    end

    assign step = run && (bypass || cnt == '0);
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] reload_val,
    input  logic             step,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= (cnt == '0) ? reload_val : cnt - 1'b1;
        end
    end

    assign tick = step && (cnt == '0);
endmodule

// File: rtl/brg_channel.sv
module brg_channel
    import brg_pkg::*;
#(
    parameter int PRE_DIV = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  brg_cfg_t cfg_in,
    output logic     tick
);
    brg_cfg_t cfg_q;
    logic     step;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

    brg_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .run    (cfg_q.en),
        .bypass (!cfg_q.pre),
        .step   (step)
    );

    brg_divider #(.DIV_W(BRG_DIV_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (cfg_in.div_m1),
        .reload_val (cfg_q.div_m1),
        .step       (step),
        .tick       (tick)
    );
endmodule

// File: rtl/brg_bank.sv
module brg_bank
    import brg_pkg::*;
#(
    parameter int NUM_GEN = 16,
    parameter int PRE_DIV = 16,
    localparam int IDX_W  = $clog2(NUM_GEN) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [BRG_WORD_W-1:0] wr_data,
    output logic [NUM_GEN-1:0]    tick,
    output logic                  cfg_err
);
    brg_cfg_t wr_cfg;
    logic     wr_valid;

    assign wr_cfg   = brg_decode(wr_data);
    assign wr_valid = wr_en && (wr_idx < IDX_W'(NUM_GEN));

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
        brg_channel #(.PRE_DIV(PRE_DIV)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .load   (wr_valid && (wr_idx == IDX_W'(g))),
            .cfg_in (wr_cfg),
            .tick   (tick[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_err <= 1'b0;
        end else if (wr_valid && brg_ratio_illegal(wr_cfg)) begin
            cfg_err <= 1'b1;
        end
    end
endmodule

// File: rtl/brg_bank_checker.sv
module brg_bank_checker
    import brg_pkg::*;
#(
    parameter int NUM_GEN = 16,
    localparam int IDX_W  = $clog2(NUM_GEN) + 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      wr_idx,
    input logic [BRG_WORD_W-1:0] wr_data,
    input logic [NUM_GEN-1:0]    tick,
    input logic                  cfg_err
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tick == '0 && !cfg_err));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> ($past(wr_en) && $past(wr_idx) < IDX_W'(NUM_GEN)
                            && !$past(wr_data[BRG_PRE_BIT])
                            && !$past(wr_data[BRG_DIV_LSB])));

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_prop
        assert_stop_R6: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(g) && !wr_data[BRG_EN_BIT]) |=> !tick[g]);

        assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(g)
             && (wr_data[BRG_PRE_BIT] || wr_data[BRG_DIV_LSB +: BRG_DIV_W] != '0))
            |=> !tick[g]);

        assert_unit_ratio_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(g) && wr_data[BRG_EN_BIT] && !wr_data[BRG_PRE_BIT]
             && wr_data[BRG_DIV_LSB +: BRG_DIV_W] == '0) |=> tick[g]);
    end
endmodule

bind brg_bank brg_bank_checker #(.NUM_GEN(NUM_GEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .tick    (tick),
    .cfg_err (cfg_err)
);

// File: tb/brg_bank_tb.sv
module brg_bank_tb;
    localparam int NUM_GEN = 16;
    localparam int IDX_W   = $clog2(NUM_GEN) + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [31:0]       wr_data = '0;
    logic [NUM_GEN-1:0] tick;
    logic              cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    brg_bank #(.NUM_GEN(NUM_GEN)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .tick(tick), .cfg_err(cfg_err)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input bit en, input bit pre, input int d);
        return (32'(d) << 8) | {30'b0, pre, en};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // returns at the negedge of cycle 0 after the write edge
    task automatic write_raw(input int idx, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int g, input int cycles,
                           output int first, output int second, output int count);
        first = -1; second = -1; count = 0;
        for (int k = 0; k < cycles; k++) begin
            if (tick[g]) begin
                if (first < 0) first = k;
                else if (second < 0) second = k;
                count++;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int f, s, c;
        do_reset();
        check(tick == '0, "R1 ticks", int'(tick), 0);
        check(!cfg_err, "R1 err", int'(cfg_err), 0);
        measure(0, 20, f, s, c);
        check(tick == '0 && c == 0, "R1 idle", c, 0);
    endtask

    task automatic t_plain();
        int f, s, c;
        write_raw(0, word(1, 0, 3));
        measure(0, 20, f, s, c);
        check(f == 3, "R3 first N=4", f, 3);
        check(s == 7, "R3 second N=4", s, 7);
        check(c == 5, "R5 count N=4", c, 5);
        write_raw(15, word(1, 0, 1));
        measure(15, 10, f, s, c);
        check(f == 1 && s == 3, "R3 N=2", f * 100 + s, 103);
        check(c == 5, "R5 count N=2", c, 5);
        check(!cfg_err, "R9 even ratio", int'(cfg_err), 0);
    endtask

    task automatic t_prescale();
        int f, s, c;
        write_raw(5, word(1, 1, 2));
        measure(5, 100, f, s, c);
        check(f == 47 && s == 95, "R4 N=3", f * 1000 + s, 47095);
        check(c == 2, "R5 prescaled count", c, 2);
        write_raw(7, word(1, 1, 0));
        measure(7, 40, f, s, c);
        check(f == 15 && s == 31, "R4 N=1", f * 1000 + s, 15031);
        check(!cfg_err, "R9 prescaler on odd ratio legal", int'(cfg_err), 0);
    endtask

    task automatic t_fields_and_stop();
        int f, s, c;
        write_raw(0, 32'hFFF0_03FD);
        measure(0, 12, f, s, c);
        check(f == 3 && s == 7, "R2 ignored bits", f * 100 + s, 307);
        check(!cfg_err, "R2 no err", int'(cfg_err), 0);
        write_raw(0, word(0, 0, 3));
        measure(0, 40, f, s, c);
        check(c == 0, "R6 stopped", c, 0);
    endtask

    task automatic t_restart();
        int f, s, c;
        write_raw(3, word(1, 0, 9));
        measure(3, 6, f, s, c);
        write_raw(3, word(1, 0, 9));
        measure(3, 25, f, s, c);
        check(f == 9 && s == 19, "R7 rewrite phase", f * 100 + s, 919);
    endtask

    task automatic t_independent();
        int f, s, c;
        write_raw(1, word(1, 0, 5));
        wr_en = 1'b1; wr_idx = IDX_W'(2); wr_data = word(1, 0, 7);
        @(negedge clk);
        wr_en = 1'b0;
        measure(1, 12, f, s, c);
        check(f == 4 && s == 10, "R8 neighbour untouched", f * 100 + s, 410);
    endtask

    task automatic t_out_of_range();
        int f, s, c;
        do_reset();
        write_raw(16, word(1, 0, 0));
        write_raw(31, word(1, 0, 0));
        measure(0, 20, f, s, c);
        check(c == 0 && tick == '0, "R11 no generator started", c, 0);
        check(!cfg_err, "R11 err untouched", int'(cfg_err), 0);
    endtask

    task automatic t_error();
        int f, s, c;
        write_raw(4, word(1, 0, 4));
        check(cfg_err, "R9 odd ratio sets err", int'(cfg_err), 1);
        measure(4, 12, f, s, c);
        check(f == 4 && s == 9, "R3 N=5 still runs", f * 100 + s, 409);
        write_raw(4, word(1, 0, 5));
        measure(4, 10, f, s, c);
        check(cfg_err, "R10 sticky", int'(cfg_err), 1);
        write_raw(6, word(1, 0, 0));
        measure(6, 10, f, s, c);
        check(c == 10, "R3 N=1 every cycle", c, 10);
        do_reset();
        check(!cfg_err && tick == '0, "R1 reset clears err", int'(cfg_err), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_prescale();
        t_fields_and_stop();
        t_restart();
        t_independent();
        t_out_of_range();
        t_error();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule